// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Unit

This unit exchanges one character at a time over a pair of serial lines while a transfer clock paces both directions. Each transfer shifts the loaded byte out on `ser_out` and, at the same time, collects a byte from `ser_in`. The unit can act as clock master or as clock slave. As master, it makes the transfer clock from a prescaled baud counter and drives it on `xclk_out`. As slave, it follows a clock arriving on `xclk_in`, which it first brings into the system clock domain.

The configuration inputs set three things. `clk_pol` picks which clock edge changes the output data and which edge captures the input. `msb_first` picks the bit order. `rate_sel` picks the prescaler, which divides the system clock by 1, 8 or 32, with the fourth code reserved. A pulse on `tx_start` while `tx_empty` is high loads `tx_data` and starts a transfer. When the transfer completes, the received byte appears on `rx_data` together with a single-cycle `rx_valid`, and `tx_empty` returns high.

Top module: `sync_serial_io`

## Requirements
- R1: While reset is held and right after it, `tx_empty`=1, `rx_valid`=0, `xclk_out`=1 and `ser_out`=1.
- R2: If `tx_start` is 1 while `tx_empty` is 1, `tx_empty` reads 0 from the next cycle. From that same cycle, `ser_out` carries the first bit of `tx_data`: bit 7 when `msb_first`=1, bit 0 when it is 0. This happens before any capture edge.
- R3: With `use_ext_clk`=0, successive toggles of `xclk_out` are exactly P*(`baud_div`+1) system cycles apart. P is 1 for `rate_sel`=00, 8 for 01 and 32 for 10.
- R4: With `rate_sel`=11 (reserved), a started transfer produces no toggle of `xclk_out`.
- R5: In master mode, `xclk_out` idles at 1. It makes exactly 16 toggles per character and is back at 1 when the transfer ends.
- R6: With `clk_pol`=0, `ser_out` changes only at falling transfer-clock edges and `ser_in` is captured at rising edges. With `clk_pol`=1 the roles of the two edges are swapped. Output edges that come before the first capture keep the first bit.
- R7: With `msb_first`=1, bits are sent and received from bit 7 down to bit 0. With `msb_first`=0, from bit 0 up to bit 7.
- R8: With `use_ext_clk`=1, `xclk_out` stays at 1 and the transfer clock comes from `xclk_in` through a two-stage synchronizer. The transfer ends at the 8th capture edge. `xclk_in` must have a period longer than four system cycles.
- R9: A transfer ends with `rx_valid` high for exactly one cycle, in the same cycle that `rx_data` shows the received byte and `tx_empty` goes to 1.
- R10: `tx_start` during a transfer has no effect on the byte being sent. Edges on `xclk_in` while idle produce no `rx_valid` and leave `ser_out` and `tx_empty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| use_ext_clk | input | 1 | 0: internal transfer clock, 1: external |
| clk_pol | input | 1 | Edge roles select for drive and capture |
| msb_first | input | 1 | Bit order select |
| rate_sel | input | 2 | Prescaler select (00 /1, 01 /8, 10 /32, 11 reserved) |
| baud_div | input | DIV_W | Baud counter reload, ticks every baud_div+1 prescaled pulses |
| tx_start | input | 1 | Start request, accepted when tx_empty is 1 |
| tx_data | input | DATA_W | Byte to send |
| xclk_in | input | 1 | External transfer clock |
| xclk_out | output | 1 | Generated transfer clock |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle completion strobe |
| tx_empty | output | 1 | 1 when no character is shifting |

## Verification
A miscounted toggle or sample counter shows up at the end of the character. It moves the `rx_valid` strobe and the return of `tx_empty` away from the 16th toggle, or away from the 8th capture edge, and it leaves bytes misaligned. A swapped edge role puts a bit that is still changing onto a capture edge, and the very first transfer then returns the wrong byte. A wrong prescaler or baud count stretches the gap between `xclk_out` toggles, which shows within two toggles of the start.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  typedef enum logic [1:0] {
    RATE_DIV1  = 2'b00,
    RATE_DIV8  = 2'b01,
    RATE_DIV32 = 2'b10,
    RATE_RSVD  = 2'b11
  } rate_e;

  localparam int PRE_MAX = 32;
  localparam int PRE_W   = $clog2(PRE_MAX);
endpackage

// File: rtl/sio_tick_gen.sv
`timescale 1ns/1ps
module sio_tick_gen
  import sio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       rate_sel,
  input  logic [DIV_W-1:0] baud_div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] baud_cnt;
  logic             pre_tick;

  always_ff @(posedge clk) begin
    if (rst || !run) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_comb begin
    case (rate_e'(rate_sel))
      RATE_DIV1:  pre_tick = 1'b1;
      RATE_DIV8:  pre_tick = (pre_cnt[2:0] == 3'd7);
      RATE_DIV32: pre_tick = (pre_cnt == PRE_W'(PRE_MAX - 1));
      default:    pre_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  baud_cnt <= '0;
    else if (pre_tick) begin
      if (baud_cnt == baud_div) baud_cnt <= '0;
      else                      baud_cnt <= baud_cnt + DIV_W'(1);
    end
  end

  assign tick = run && pre_tick && (baud_cnt == baud_div);

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && baud_div != '0) |=> (!tick || baud_div != $past(baud_div) || rate_sel != $past(rate_sel)));

  assert_rsvd_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'b11) |-> !tick);
endmodule

// File: rtl/sio_edge_sync.sv
`timescale 1ns/1ps
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

  assert_edge_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));

  assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sync_serial_io.sv
`timescale 1ns/1ps
module sync_serial_io #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_ext_clk,
  input  logic              clk_pol,
  input  logic              msb_first,
  input  logic [1:0]        rate_sel,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              xclk_in,
  output logic              xclk_out,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_empty
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int TOG_W = $clog2(2 * DATA_W);
  localparam logic [TOG_W-1:0] LAST_TOG = TOG_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              busy_q, sclk_q, sdo_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q;
  logic [CNT_W-1:0]  nsamp;
  logic [TOG_W-1:0]  ntog;
  logic              valid_q, empty_q;

  logic int_tick, x_rise, x_fall;
  logic rise_ev, fall_ev, sample_ev, drive_ev;
  logic start, do_sample, do_drive, finish;
  logic [DATA_W-1:0] rx_next, tx_next;
  logic              next_bit, first_bit;

  sio_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q & ~use_ext_clk),
    .rate_sel (rate_sel),
    .baud_div (baud_div),
    .tick     (int_tick)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (xclk_in),
    .rise     (x_rise),
    .fall     (x_fall)
  );

  always_comb begin
    if (use_ext_clk) begin
      rise_ev = busy_q & x_rise;
      fall_ev = busy_q & x_fall;
    end else begin
      rise_ev = int_tick & ~sclk_q;
      fall_ev = int_tick & sclk_q;
    end
    sample_ev = clk_pol ? fall_ev : rise_ev;
    drive_ev  = clk_pol ? rise_ev : fall_ev;
  end

  assign start     = tx_start & ~busy_q;
  assign do_sample = busy_q && sample_ev && (nsamp < ALL_BITS);
  assign do_drive  = busy_q && drive_ev && (nsamp != '0) && (nsamp < ALL_BITS);
  assign first_bit = msb_first ? tx_data[DATA_W-1] : tx_data[0];

  always_comb begin
    if (msb_first) begin
      tx_next  = tx_sh << 1;
      next_bit = tx_sh[DATA_W-2];
    end else begin
      tx_next  = tx_sh >> 1;
      next_bit = tx_sh[1];
    end
    if (!do_sample)     rx_next = rx_sh;
    else if (msb_first) rx_next = {rx_sh[DATA_W-2:0], ser_in};
    else                rx_next = {ser_in, rx_sh[DATA_W-1:1]};
  end

  assign finish = busy_q && (use_ext_clk ? (do_sample && nsamp == LAST_BIT)
                                         : (int_tick && ntog == LAST_TOG));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b1;
      sdo_q   <= 1'b1;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      nsamp   <= '0;
      ntog    <= '0;
      valid_q <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        sclk_q  <= 1'b1;
        tx_sh   <= tx_data;
        sdo_q   <= first_bit;
        nsamp   <= '0;
        ntog    <= '0;
        empty_q <= 1'b0;
      end else if (busy_q) begin
        if (int_tick) begin
          sclk_q <= ~sclk_q;
          ntog   <= ntog + TOG_W'(1);
        end
        rx_sh <= rx_next;
        if (do_sample) nsamp <= nsamp + CNT_W'(1);
        if (do_drive) begin
          tx_sh <= tx_next;
          sdo_q <= next_bit;
        end
        if (finish) begin
          busy_q  <= 1'b0;
          rx_q    <= rx_next;
          valid_q <= 1'b1;
          empty_q <= 1'b1;
        end
      end
    end
  end

  assign xclk_out = sclk_q;
  assign ser_out  = sdo_q;
  assign rx_data  = rx_q;
  assign rx_valid = valid_q;
  assign tx_empty = empty_q;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_start && tx_empty) |=> !tx_empty);

  assert_first_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_start && tx_empty && msb_first) |=> (ser_out == $past(tx_data[DATA_W-1])));

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> xclk_out);

  assert_samp_bound_R5: assert property (@(posedge clk) disable iff (rst)
    nsamp <= ALL_BITS);

  assert_hold_on_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && sample_ev) |=> $stable(ser_out));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_empty_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> tx_empty);

  assert_empty_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> rx_valid);
endmodule

// File: tb/tb_sync_serial_io.sv
`timescale 1ns/1ps
module tb_sync_serial_io;
  localparam int DW = 8;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          use_ext_clk = 1'b0, clk_pol = 1'b0, msb_first = 1'b0;
  logic [1:0]    rate_sel = 2'b00;
  logic [VW-1:0] baud_div = '0;
  logic          tx_start = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          xclk_in = 1'b1, ser_in = 1'b1;
  logic          xclk_out, ser_out, rx_valid, tx_empty;
  logic [DW-1:0] rx_data;

  int errors = 0, checks = 0, cyc = 0, vcnt = 0;
  logic [DW-1:0] last_rx = '0;
  bit ext_low_seen = 0;

  sync_serial_io #(.DATA_W(DW), .DIV_W(VW)) dut (
    .clk(clk), .rst(rst), .use_ext_clk(use_ext_clk), .clk_pol(clk_pol),
    .msb_first(msb_first), .rate_sel(rate_sel), .baud_div(baud_div),
    .tx_start(tx_start), .tx_data(tx_data), .xclk_in(xclk_in),
    .xclk_out(xclk_out), .ser_in(ser_in), .ser_out(ser_out),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rx_valid) begin
      vcnt++;
      last_rx = rx_data;
      check(tx_empty == 1'b1, "R9 tx_empty with rx_valid", int'(tx_empty), 1);
    end
    if (use_ext_clk && !xclk_out) ext_low_seen = 1;
  endtask

  function automatic int bidx(input bit msb, input int k);
    return msb ? (DW - 1 - k) : k;
  endfunction

  task automatic reset_check(input string tag);
    check(tx_empty == 1'b1, {tag, " tx_empty"}, int'(tx_empty), 1);
    check(rx_valid == 1'b0, {tag, " rx_valid"}, int'(rx_valid), 0);
    check(xclk_out == 1'b1, {tag, " xclk_out"}, int'(xclk_out), 1);
    check(ser_out == 1'b1, {tag, " ser_out"}, int'(ser_out), 1);
  endtask

  // Master-mode transfer with the bench acting as slave (R3 R5 R6 R7 R9 R10)
  task automatic run_int(input bit pol, input bit msb, input int rs, input int dv,
                         input logic [DW-1:0] txd, input logic [DW-1:0] rxb);
    int per, v0, ntog, ns, bad_int, bad_drv, last_t, poked;
    logic prev;
    logic [DW-1:0] cap;
    bit fall, is_samp;
    per = ((rs == 0) ? 1 : (rs == 1) ? 8 : 32) * (dv + 1);
    use_ext_clk = 0; clk_pol = pol; msb_first = msb;
    rate_sel = 2'(rs); baud_div = VW'(dv);
    tx_data = txd; ser_in = rxb[bidx(msb, 0)];
    v0 = vcnt; ntog = 0; ns = 0; bad_int = 0; bad_drv = 0; last_t = 0; poked = 0; cap = '0;
    prev = xclk_out;
    tx_start = 1; step(); tx_start = 0;
    check(tx_empty == 1'b0, "R2 busy after start", int'(tx_empty), 0);
    check(ser_out == txd[bidx(msb, 0)], "R2 first bit", int'(ser_out), int'(txd[bidx(msb, 0)]));
    for (int n = 0; n < 4000; n++) begin
      step();
      if (poked == 1) begin tx_start = 0; tx_data = txd; poked = 2; end
      if (xclk_out != prev) begin
        ntog++;
        if (ntog >= 2 && (cyc - last_t) != per) bad_int++;
        last_t = cyc; prev = xclk_out;
        fall = !xclk_out;
        is_samp = pol ? fall : !fall;
        if (is_samp) begin
          if (ns < DW) cap[bidx(msb, ns)] = ser_out;
          ns++;
        end else if (ns >= 1 && ns < DW) begin
          if (ser_out != txd[bidx(msb, ns)]) bad_drv++;
          ser_in = rxb[bidx(msb, ns)];
        end
        if (ntog == 5 && poked == 0) begin tx_start = 1; tx_data = ~txd; poked = 1; end
      end
      if (tx_empty) break;
    end
    repeat (3) step();
    check(ntog == 16, "R5 toggle count", ntog, 16);
    check(xclk_out == 1'b1, "R5 idle level after transfer", int'(xclk_out), 1);
    check(bad_int == 0, "R3 toggle spacing", bad_int, 0);
    check(bad_drv == 0, "R6 output edge data", bad_drv, 0);
    check(vcnt - v0 == 1, "R9 single rx_valid", vcnt - v0, 1);
    check(last_rx == rxb, "R7 received byte", int'(last_rx), int'(rxb));
    check(cap == txd, "R10 sent byte despite busy start", int'(cap), int'(txd));
  endtask

  // Slave-mode transfer with the bench acting as clock master (R8)
  task automatic run_ext(input bit pol, input bit msb,
                         input logic [DW-1:0] txd, input logic [DW-1:0] rxb);
    int v0, ns;
    logic [DW-1:0] cap;
    bit fall;
    use_ext_clk = 1; clk_pol = pol; msb_first = msb;
    xclk_in = 1; tx_data = txd; ser_in = rxb[bidx(msb, 0)];
    ext_low_seen = 0; v0 = vcnt; ns = 0; cap = '0;
    repeat (4) step();
    tx_start = 1; step(); tx_start = 0;
    check(ser_out == txd[bidx(msb, 0)], "R2 first bit ext", int'(ser_out), int'(txd[bidx(msb, 0)]));
    for (int e = 0; e < 16; e++) begin
      repeat (6) step();
      xclk_in = ~xclk_in;
      fall = !xclk_in;
      if (pol ? fall : !fall) begin
        if (ns < DW) cap[bidx(msb, ns)] = ser_out;
        ns++;
      end else if (ns >= 1 && ns < DW) begin
        ser_in = rxb[bidx(msb, ns)];
      end
    end
    repeat (12) step();
    check(vcnt - v0 == 1, "R8 single completion ext", vcnt - v0, 1);
    check(last_rx == rxb, "R8 received byte ext", int'(last_rx), int'(rxb));
    check(cap == txd, "R8 sent byte ext", int'(cap), int'(txd));
    check(ext_low_seen == 0, "R8 xclk_out held high", int'(ext_low_seen), 0);
    check(tx_empty == 1'b1, "R9 tx_empty after ext", int'(tx_empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx;
    logic [DW-1:0] td, rb, sdo0;
    int v0;
    bit toggled;
    rst = 1;
    repeat (3) step();
    reset_check("R1 in reset");
    rst = 0;
    step();
    reset_check("R1 after reset");

    idx = 0;
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int r = 0; r < 3; r++)
          for (int d = 0; d < 3; d++) begin
            td = DW'(8'h3C ^ (idx * 29));
            rb = {td[3:0], td[7:4]} ^ 8'h96;
            run_int(p[0], m[0], r, d, td, rb);
            idx++;
          end

    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++) begin
        td = DW'(8'hB1 + p * 70 + m * 19);
        rb = ~{td[0], td[7:1]};
        run_ext(p[0], m[0], td, rb);
      end

    // R10: external edges while idle
    use_ext_clk = 1; xclk_in = 1; v0 = vcnt; sdo0 = {7'b0, ser_out};
    for (int e = 0; e < 16; e++) begin
      repeat (6) step();
      xclk_in = ~xclk_in;
      ser_in = ~ser_in;
    end
    repeat (10) step();
    check(vcnt == v0, "R10 idle edges no rx_valid", vcnt - v0, 0);
    check(tx_empty == 1'b1, "R10 idle edges tx_empty", int'(tx_empty), 1);
    check(ser_out == sdo0[0], "R10 idle edges ser_out", int'(ser_out), int'(sdo0[0]));

    // R4: reserved rate code
    use_ext_clk = 0; rate_sel = 2'b11; baud_div = '0; tx_data = 8'h5A;
    toggled = 0;
    tx_start = 1; step(); tx_start = 0;
    for (int n = 0; n < 200; n++) begin
      step();
      if (!xclk_out) toggled = 1;
    end
    check(toggled == 0, "R4 reserved rate no toggles", int'(toggled), 0);
    check(tx_empty == 1'b0, "R4 reserved rate still busy", int'(tx_empty), 0);
    rst = 1; step(); step(); rst = 0; step();
    reset_check("R1 after second reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule